// File: doc/BRIEF.md
# Stepped Permutation Sequencer

This block runs a keyed-free, round-based permutation over a register-held state of 4, 6 or 8 branches. Each branch holds two 32-bit words, x and y. The caller loads the state word by word, pulses start with a branch count and a step count, waits for done, and then reads the permuted state back.

Every step runs three phases in a fixed order:

1. A step-dependent constant is folded into the state.
2. An add-rotate-xor box is applied to each branch in turn. The box for each branch is keyed with that branch's own constant.
3. A linear diffusion layer mixes the two halves of the branch set.

An internal step counter counts the steps performed. The constants come from an eight-entry table that is computed in logic.

Top module: `perm_seq`

## Requirements
- R1: After reset, busy and done are 0 and all 16 state words read as zero.
- R2: While busy is 0, a cycle with wr_en writes wr_data into the word at wr_addr. An even address 2i selects x of branch i, and an odd address 2i+1 selects y of branch i. rd_data shows the word at rd_addr combinationally. With no write and no start, the state does not change.
- R3: A start with n_steps equal to 0 leaves the state untouched and raises done in the cycle after start, with busy staying 0.
- R4: At the beginning of step s, y of branch 0 is XORed with constant T[s mod 8]. The table T in index order is: 0xB7E15162, 0xBF715880, 0x38B4DA56, 0x324E7738, 0xBB1185EB, 0x4F7C7B57, 0xCFBFA1C8, 0xC2B3293D.
- R5: At the beginning of step s, the 8-bit step number s (zero-extended) is XORed into x of branch 1.
- R6: Branch i (0 ≤ i < nb) passes through four rounds with constant c = T[i]. Each round does x += (y >>> a); y ^= (x >>> b); x ^= c. The pairs (a,b) are (31,24), (17,17), (0,31), (24,16), and >>> is a 32-bit right rotation.
- R7: Let h = nb/2 and L(v) = (v ^ (v << 16)) >>> 16. Let lx be L of the XOR of x over branches 0..h-1, and ly be L of the XOR of y over the same branches. For i < h, the new x[i] is x[i+1] ^ x[(i+1+h) mod nb] ^ ly, and the new y[i] is y[i+1] ^ y[(i+1+h) mod nb] ^ lx. For h ≤ i < nb, the new branch i is the old branch i-h.
- R8: The step counter starts at 0 and increments after each complete step. A run of n steps yields exactly n repetitions of R4/R5, then R6 over all branches, then R7, and then stops. This holds for n above 8, where the table index wraps.
- R9: busy rises in the cycle after an accepted start and stays 1 until done. done is a one-cycle pulse, and busy and done are never 1 together.
- R10: While busy is 1, wr_en and start are ignored, and a run's result is the same as if they were never driven.
- R11: n_branch may be 4, 6 or 8. State words at addresses 2·nb and above are not changed by a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when busy is 0) |
| n_branch | input | 4 | Branch count for the run: 4, 6 or 8 |
| n_steps | input | 8 | Number of steps to perform |
| wr_en | input | 1 | Write strobe for one state word |
| wr_addr | input | 4 | Word address: 2i = x of branch i, 2i+1 = y of branch i |
| wr_data | input | 32 | Word to write |
| rd_addr | input | 4 | Word address to read |
| rd_data | output | 32 | Word at rd_addr |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The hardest situation to create from the ports is a stray write or a second start that lands in the middle of a run. Both have to arrive after the first start has been taken but before done. The stimulus therefore drives a write to branch 0 and a new start with a different step count on the very next cycle after start, while the injection phase is active. It then compares the final state word for word with a reference model that never saw either input. The wrap of the constant index is reached only by runs longer than eight steps, so the bench uses step counts of 10 and 11. Those runs use different branch counts, and the bench checks that the words above the active branches are left alone.

// File: rtl/perm_seq_pkg.sv
package perm_seq_pkg;

    parameter int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t x;
        word_t y;
    } branch_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_INJ,
        SQ_ARX,
        SQ_LGO,
        SQ_LWT,
        SQ_FIN
    } seq_st_e;

    // right rotation of one word
    function automatic word_t rotr(word_t v, int unsigned n);
        if (n == 0) begin
            return v;
        end
        return (v >> n) | (v << (WORD_W - n));
    endfunction

    // eight-entry constant table
    function automatic word_t rcon(logic [2:0] idx);
        word_t r;
        case (idx)
            3'd0:    r = 32'hB7E15162;
            3'd1:    r = 32'hBF715880;
            3'd2:    r = 32'h38B4DA56;
            3'd3:    r = 32'h324E7738;
            3'd4:    r = 32'hBB1185EB;
            3'd5:    r = 32'h4F7C7B57;
            3'd6:    r = 32'hCFBFA1C8;
            default: r = 32'hC2B3293D;
        endcase
        return r;
    endfunction

    // one of the four rounds of the add-rotate-xor box
    function automatic branch_t arx_round(branch_t b, word_t c, logic [1:0] r);
        int unsigned ra;
        int unsigned rb;
        branch_t     o;
        case (r)
            2'd0:    begin ra = 31; rb = 24; end
            2'd1:    begin ra = 17; rb = 17; end
            2'd2:    begin ra = 0;  rb = 31; end
            default: begin ra = 24; rb = 16; end
        endcase
        o.x = b.x + rotr(b.y, ra);
        o.y = b.y ^ rotr(o.x, rb);
        o.x = o.x ^ c;
        return o;
    endfunction

    // half-word fold used by the diffusion layer
    function automatic word_t fold16(word_t v);
        return rotr(v ^ (v << 16), 16);
    endfunction

endpackage

// File: rtl/perm_arx_unit.sv
module perm_arx_unit
    import perm_seq_pkg::*;
#(
    parameter int NB_MAX = 8,
    parameter int BR_W   = $clog2(NB_MAX + 1),
    parameter int IDX_W  = $clog2(NB_MAX)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  logic [BR_W-1:0]        nb,
    input  branch_t [NB_MAX-1:0]   state_in,
    output logic                   wb_en,
    output logic [IDX_W-1:0]       wb_idx,
    output branch_t                wb_val,
    output logic                   fin
);

    typedef enum logic [1:0] {AX_IDLE, AX_LOAD, AX_RUN} ax_e;

    ax_e              ph_q;
    logic [IDX_W-1:0] br_q;
    logic [1:0]       rnd_q;
    branch_t          cur_q;
    branch_t          nxt;
    logic             last_br;

    assign last_br = (BR_W'(br_q) == nb - 1'b1);
    assign nxt     = arx_round(cur_q, rcon(3'(br_q)), rnd_q);
    assign wb_en   = (ph_q == AX_RUN) && (rnd_q == 2'd3);
    assign wb_idx  = br_q;
    assign wb_val  = nxt;
    assign fin     = wb_en && last_br;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= AX_IDLE;
            br_q  <= '0;
            rnd_q <= '0;
            cur_q <= '0;
        end else begin
            case (ph_q)
                AX_IDLE: begin
                    if (go) begin
                        br_q <= '0;
                        ph_q <= AX_LOAD;
                    end
                end
                AX_LOAD: begin
                    cur_q <= state_in[br_q];
                    rnd_q <= '0;
                    ph_q  <= AX_RUN;
                end
                default: begin
                    cur_q <= nxt;
                    rnd_q <= rnd_q + 2'd1;
                    if (rnd_q == 2'd3) begin
                        if (last_br) begin
                            ph_q <= AX_IDLE;
                        end else begin
                            br_q <= br_q + 1'b1;
                            ph_q <= AX_LOAD;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/perm_lin_unit.sv
module perm_lin_unit
    import perm_seq_pkg::*;
#(
    parameter int NB_MAX = 8,
    parameter int BR_W   = $clog2(NB_MAX + 1),
    parameter int IDX_W  = $clog2(NB_MAX)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  logic [BR_W-1:0]        nb,
    input  branch_t [NB_MAX-1:0]   state_in,
    output branch_t [NB_MAX-1:0]   state_out,
    output logic                   done
);

    localparam int HALF_MAX = NB_MAX / 2;

    logic [BR_W-1:0]       half;
    word_t                 lx;
    word_t                 ly;
    branch_t [NB_MAX-1:0]  nxt;
    branch_t [NB_MAX-1:0]  res_q;
    logic                  done_q;

    assign half = nb >> 1;

    always_comb begin
        word_t ax;
        word_t ay;
        ax = '0;
        ay = '0;
        for (int i = 0; i < HALF_MAX; i++) begin
            if (BR_W'(i) < half) begin
                ax = ax ^ state_in[i].x;
                ay = ay ^ state_in[i].y;
            end
        end
        lx = fold16(ax);
        ly = fold16(ay);
    end

    for (genvar gi = 0; gi < NB_MAX; gi++) begin : g_br
        logic [BR_W-1:0] src;
        logic [BR_W-1:0] far;

        assign src = BR_W'(gi) - half;

        if (gi < HALF_MAX) begin : g_lo
            always_comb begin
                far = BR_W'(gi + 1) + half;
                if (far >= nb) begin
                    far = far - nb;
                end
                if (BR_W'(gi) < half) begin
                    nxt[gi].x = state_in[gi + 1].x ^ state_in[far[IDX_W-1:0]].x ^ ly;
                    nxt[gi].y = state_in[gi + 1].y ^ state_in[far[IDX_W-1:0]].y ^ lx;
                end else if (BR_W'(gi) < nb) begin
                    nxt[gi] = state_in[src[IDX_W-1:0]];
                end else begin
                    nxt[gi] = state_in[gi];
                end
            end
        end else begin : g_hi
            assign far = '0;
            always_comb begin
                if (BR_W'(gi) < nb) begin
                    nxt[gi] = state_in[src[IDX_W-1:0]];
                end else begin
                    nxt[gi] = state_in[gi];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= go;
            if (go) begin
                res_q <= nxt;
            end
        end
    end

    assign state_out = res_q;
    assign done      = done_q;

endmodule

// File: rtl/perm_seq.sv
module perm_seq
    import perm_seq_pkg::*;
#(
    parameter int NB_MAX = 8,
    parameter int STEP_W = 8,
    localparam int ADDR_W = $clog2(2 * NB_MAX),
    localparam int BR_W   = $clog2(NB_MAX + 1),
    localparam int IDX_W  = $clog2(NB_MAX)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [BR_W-1:0]    n_branch,
    input  logic [STEP_W-1:0]  n_steps,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    output logic               busy,
    output logic               done
);

    seq_st_e               st_q;
    branch_t [NB_MAX-1:0]  arr_q;
    logic [STEP_W-1:0]     step_q;
    logic [STEP_W-1:0]     steps_q;
    logic [BR_W-1:0]       nb_q;
    logic [STEP_W-1:0]     step_nx;

    logic                  arx_go;
    logic                  arx_wb;
    logic [IDX_W-1:0]      arx_idx;
    branch_t               arx_val;
    logic                  arx_fin;

    logic                  lin_go;
    branch_t [NB_MAX-1:0]  lin_res;
    logic                  lin_done;

    logic                  idle_ish;
    logic [IDX_W-1:0]      wr_br;
    logic [IDX_W-1:0]      rd_br;

    assign idle_ish = (st_q == SQ_IDLE) || (st_q == SQ_FIN);
    assign busy     = !idle_ish;
    assign done     = (st_q == SQ_FIN);
    assign arx_go   = (st_q == SQ_INJ);
    assign lin_go   = (st_q == SQ_LGO);
    assign step_nx  = step_q + 1'b1;
    assign wr_br    = wr_addr[ADDR_W-1:1];
    assign rd_br    = rd_addr[ADDR_W-1:1];
    assign rd_data  = rd_addr[0] ? arr_q[rd_br].y : arr_q[rd_br].x;

    perm_arx_unit #(
        .NB_MAX (NB_MAX),
        .BR_W   (BR_W),
        .IDX_W  (IDX_W)
    ) u_arx (
        .clk      (clk),
        .rst      (rst),
        .go       (arx_go),
        .nb       (nb_q),
        .state_in (arr_q),
        .wb_en    (arx_wb),
        .wb_idx   (arx_idx),
        .wb_val   (arx_val),
        .fin      (arx_fin)
    );

    perm_lin_unit #(
        .NB_MAX (NB_MAX),
        .BR_W   (BR_W),
        .IDX_W  (IDX_W)
    ) u_lin (
        .clk       (clk),
        .rst       (rst),
        .go        (lin_go),
        .nb        (nb_q),
        .state_in  (arr_q),
        .state_out (lin_res),
        .done      (lin_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            arr_q   <= '0;
            step_q  <= '0;
            steps_q <= '0;
            nb_q    <= '0;
        end else begin
            case (st_q)
                SQ_IDLE, SQ_FIN: begin
                    st_q <= SQ_IDLE;
                    if (wr_en) begin
                        if (wr_addr[0]) begin
                            arr_q[wr_br].y <= wr_data;
                        end else begin
                            arr_q[wr_br].x <= wr_data;
                        end
                    end
                    if (start) begin
                        nb_q    <= n_branch;
                        steps_q <= n_steps;
                        step_q  <= '0;
                        st_q    <= (n_steps == '0) ? SQ_FIN : SQ_INJ;
                    end
                end
                SQ_INJ: begin
                    arr_q[0].y <= arr_q[0].y ^ rcon(step_q[2:0]);
                    arr_q[1].x <= arr_q[1].x ^ WORD_W'(step_q);
                    st_q       <= SQ_ARX;
                end
                SQ_ARX: begin
                    if (arx_wb) begin
                        arr_q[arx_idx] <= arx_val;
                    end
                    if (arx_fin) begin
                        st_q <= SQ_LGO;
                    end
                end
                SQ_LGO: begin
                    st_q <= SQ_LWT;
                end
                default: begin
                    if (lin_done) begin
                        arr_q  <= lin_res;
                        step_q <= step_nx;
                        st_q   <= (step_nx == steps_q) ? SQ_FIN : SQ_INJ;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/perm_seq_chk.sv
module perm_seq_chk
    import perm_seq_pkg::*;
#(
    parameter int NB_MAX = 8,
    parameter int STEP_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic                  wr_en,
    input logic                  busy,
    input logic                  done,
    input logic [STEP_W-1:0]     n_steps,
    input logic [STEP_W-1:0]     step_q,
    input logic [STEP_W-1:0]     steps_q,
    input branch_t [NB_MAX-1:0]  arr_q
);

    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_start_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && n_steps != '0) |=> busy);

    p_busy_until_done_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy || done));

    p_zero_steps_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && n_steps == '0) |=> (done && !busy));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !wr_en && !start) |=> $stable(arr_q));

    p_step_bound_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (step_q < steps_q));

endmodule

bind perm_seq perm_seq_chk #(
    .NB_MAX (NB_MAX),
    .STEP_W (STEP_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .wr_en   (wr_en),
    .busy    (busy),
    .done    (done),
    .n_steps (n_steps),
    .step_q  (step_q),
    .steps_q (steps_q),
    .arr_q   (arr_q)
);

// File: tb/perm_seq_tb.sv
`timescale 1ns/1ps
module perm_seq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  n_branch;
    logic [7:0]  n_steps;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic        busy;
    logic        done;

    always #10 clk = ~clk;

    perm_seq u_dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .n_branch (n_branch),
        .n_steps  (n_steps),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .busy     (busy),
        .done     (done)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] mdl [16];

    typedef struct {
        string       tag;
        logic [3:0]  addr;
        logic [31:0] val;
    } exp_t;
    exp_t exp_q [$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] rr(logic [31:0] v, int n);
        return (v >> n) | (v << (32 - n));
    endfunction

    function automatic logic [31:0] tconst(int i);
        case (i)
            0: return 32'hB7E15162;
            1: return 32'hBF715880;
            2: return 32'h38B4DA56;
            3: return 32'h324E7738;
            4: return 32'hBB1185EB;
            5: return 32'h4F7C7B57;
            6: return 32'hCFBFA1C8;
            default: return 32'hC2B3293D;
        endcase
    endfunction

    function automatic logic [31:0] lfold(logic [31:0] v);
        return rr(v ^ (v << 16), 16);
    endfunction

    // reference model of R4..R8 on the mirror array
    task automatic ref_run(int nb, int ns);
        for (int s = 0; s < ns; s++) begin
            logic [31:0] tx, ty, x0, y0, x, y, c;
            int h;
            mdl[1] = mdl[1] ^ tconst(s % 8);
            mdl[2] = mdl[2] ^ 32'(s & 8'hFF);
            for (int b = 0; b < nb; b++) begin
                x = mdl[2*b]; y = mdl[2*b+1]; c = tconst(b);
                x = x + rr(y, 31); y = y ^ rr(x, 24); x = x ^ c;
                x = x + rr(y, 17); y = y ^ rr(x, 17); x = x ^ c;
                x = x + y;         y = y ^ rr(x, 31); x = x ^ c;
                x = x + rr(y, 24); y = y ^ rr(x, 16); x = x ^ c;
                mdl[2*b] = x; mdl[2*b+1] = y;
            end
            h = nb / 2;
            tx = '0; ty = '0;
            for (int b = 0; b < h; b++) begin
                tx = tx ^ mdl[2*b];
                ty = ty ^ mdl[2*b+1];
            end
            tx = lfold(tx); ty = lfold(ty);
            x0 = mdl[0]; y0 = mdl[1];
            for (int j = 1; j < h; j++) begin
                mdl[2*j-2]    = mdl[2*j+nb] ^ mdl[2*j] ^ ty;
                mdl[2*j+nb]   = mdl[2*j];
                mdl[2*j-1]    = mdl[2*j+nb+1] ^ mdl[2*j+1] ^ tx;
                mdl[2*j+nb+1] = mdl[2*j+1];
            end
            mdl[nb-2] = mdl[nb] ^ x0 ^ ty;
            mdl[nb]   = x0;
            mdl[nb-1] = mdl[nb+1] ^ y0 ^ tx;
            mdl[nb+1] = y0;
        end
    endtask

    task automatic wr_word(int a, logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        mdl[a] = v;
    endtask

    // driver side: queue expected readout
    task automatic expect_all(string tag);
        for (int a = 0; a < 16; a++) begin
            exp_t e;
            e.tag = tag; e.addr = 4'(a); e.val = mdl[a];
            exp_q.push_back(e);
        end
    endtask

    // monitor side: pop and compare against the port
    task automatic monitor_drain();
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            rd_addr = e.addr;
            #2;
            chk(e.tag, rd_data, e.val);
        end
    endtask

    task automatic run(int nb, int ns, bit disturb, string tag);
        int cnt;
        @(negedge clk);
        start = 1'b1; n_branch = 4'(nb); n_steps = 8'(ns);
        @(negedge clk);
        start = 1'b0;
        if (ns == 0) begin
            chk({tag, " R3 done next cycle"}, 32'(done), 32'd1);
            chk({tag, " R3 busy low"}, 32'(busy), 32'd0);
            @(negedge clk);
            expect_all({tag, " R3 state kept"});
            monitor_drain();
            return;
        end
        chk({tag, " R9 busy after start"}, 32'(busy), 32'd1);
        chk({tag, " R9 no early done"}, 32'(done), 32'd0);
        if (disturb) begin
            // R10: write and restart while busy
            wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'hDEADBEEF;
            start = 1'b1; n_steps = 8'd3;
            @(negedge clk);
            wr_en = 1'b0; start = 1'b0;
        end
        cnt = 0;
        while (!done && cnt < 20000) begin
            @(negedge clk);
            cnt++;
        end
        chk({tag, " R9 done seen"}, 32'(done), 32'd1);
        chk({tag, " R9 busy low at done"}, 32'(busy), 32'd0);
        @(negedge clk);
        chk({tag, " R9 done pulse"}, 32'(done), 32'd0);
        ref_run(nb, ns);
        expect_all(tag);
        monitor_drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; n_branch = 4'd4; n_steps = 8'd0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        for (int a = 0; a < 16; a++) mdl[a] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        expect_all("R1 zero state");
        monitor_drain();

        // R2 write and read
        for (int a = 0; a < 16; a++) wr_word(a, {4'(a), 12'hA5C, 16'(~a)});
        expect_all("R2 readback");
        monitor_drain();

        // R3 zero steps
        run(4, 0, 1'b0, "R3");

        // single step from an all-zero state
        for (int a = 0; a < 16; a++) wr_word(a, 32'h0);
        run(4, 1, 1'b0, "R4 R5 R6 R7 one step nb4, R11 upper");

        // longer runs, table wrap
        for (int a = 0; a < 16; a++) wr_word(a, 32'h01234567 * (a + 1));
        run(4, 10, 1'b0, "R8 R4 ten steps nb4, R11 upper");
        run(6, 7, 1'b1, "R10 R11 nb6 disturbed");
        run(8, 11, 1'b0, "R8 R6 R11 nb8");
        run(8, 1, 1'b0, "R5 R7 nb8 single");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule